// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of an eight-pin general-purpose I/O expander. A host reaches it through a byte-wide access port. The port has an 8-bit pointer, a write strobe with write data, and a read strobe that loads a registered read-data output. Behind the port are five functions: a read-only view of the pins, a latched output value, per-pin input inversion, a per-pin direction setting, and a timeout-enable flag for the serial front end. The serial front end itself is a separate block. The bank drives a per-pin output enable and output level, and it samples the pin levels it is given.

An active-low external reset input is separate from the system reset. While the external reset is low, every pin output enable is forced off at once, and every register returns to its default value at each clock edge. A pin whose enable is low is an input, and its driver is in high impedance. The open-drain behaviour of pin 0 belongs to the pad. Here it appears only as that pin's enable.

Top module: `gpio_xpdr_bank`

## Requirements
- R1: After system reset `rst_n` is released, the registers hold their defaults: output latch 0x00, polarity 0xF0 (upper half set), direction 0xFF (all inputs), timeout enable 1. `rd_data` is 0x00.
- R2: The pointer encoding is 0x00 input view, 0x01 output latch, 0x02 polarity, 0x03 direction and 0x04 timeout. A read strobe loads `rd_data` at the next clock edge with the addressed value. Without a read strobe, `rd_data` holds its value.
- R3: A write to 0x01 changes `pin_out` from the clock edge that takes the strobe. A read of 0x01 returns the latched value, whatever the pin levels are.
- R4: A direction bit of 1 makes that pin an input (`pin_oe` 0). A bit of 0 makes it an output (`pin_oe` 1). The direction register is written at 0x03, and the change is visible from the next clock edge.
- R5: A read of 0x00 captures `pin_in` XOR polarity for all pins, outputs included, as sampled at the strobed clock edge.
- R6: The polarity register at 0x02 can be written and read back. A bit of 1 inverts that pin in the input view.
- R7: Bit 0 of a write to 0x04 sets `tmo_en`, and the other bits are discarded. A read of 0x04 returns 0x00 or 0x01.
- R8: Writes to 0x00 and to 0x05 through 0xFF change no register and no output. Reads from 0x05 through 0xFF return 0x00.
- R9: While `ext_rst_n` is low, `pin_oe` is all zero in the same cycle. Every register takes its R1 default at each clock edge where `ext_rst_n` is low, and that takes priority over a write.
- R10: When a read and a write address the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ext_rst_n | input | 1 | External pin reset, active low |
| reg_ptr | input | 8 | Register pointer |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| pin_out | output | 8 | Per-pin output level |
| tmo_en | output | 1 | Bus timeout enable to the serial front end |

## Verification
Three kinds of result arrive at different times:
- A write becomes visible on `pin_out`, `pin_oe` or `tmo_en` just after the clock edge that takes the strobe.
- A read result appears on `rd_data` after that same edge.
- The pin enables drop in the same cycle that the external reset goes low.

The bench drives inputs on the falling edge. It updates its model at the rising edge, using the inputs that were present at that edge, and compares one nanosecond later. This lets one check per cycle cover both the write latency and the read latency. For the combinational enable masking, the bench makes an extra comparison before the edge.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int PTR_W = 8;

  typedef enum logic [2:0] {
    SEL_IN   = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_POL  = 3'd2,
    SEL_DIR  = 3'd3,
    SEL_TMO  = 3'd4,
    SEL_NONE = 3'd7
  } gx_sel_e;

  function automatic gx_sel_e gx_decode(input logic [PTR_W-1:0] p);
    case (p)
      8'h00:   return SEL_IN;
      8'h01:   return SEL_OUT;
      8'h02:   return SEL_POL;
      8'h03:   return SEL_DIR;
      8'h04:   return SEL_TMO;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gx_regs.sv
module gx_regs import gx_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_rst_n,
  input  logic         wr_stb,
  input  gx_sel_e      wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] dir_q,
  output logic         tmo_q,
  output logic         wr_take
);
  localparam logic [W-1:0] OUT_RST = '0;
  localparam logic [W-1:0] POL_RST = ~({W{1'b1}} >> (W/2));
  localparam logic [W-1:0] DIR_RST = '1;
  localparam logic         TMO_RST = 1'b1;

  // a write that lands on a writable register
  assign wr_take = wr_stb && ext_rst_n &&
                   (wr_sel == SEL_OUT || wr_sel == SEL_POL ||
                    wr_sel == SEL_DIR || wr_sel == SEL_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      dir_q <= DIR_RST;
      tmo_q <= TMO_RST;
    end else if (!ext_rst_n) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      dir_q <= DIR_RST;
      tmo_q <= TMO_RST;
    end else if (wr_take) begin
      case (wr_sel)
        SEL_OUT: out_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        SEL_TMO: tmo_q <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gx_pindrv.sv
module gx_pindrv #(
  parameter int W = 8
) (
  input  logic         ext_rst_n,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    // direction bit 1 = input, external reset forces input
    assign pin_oe[i]  = ext_rst_n & ~dir_q[i];
    assign pin_out[i] = out_q[i];
  end
endmodule

// File: rtl/gx_rdport.sv
module gx_rdport import gx_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_stb,
  input  gx_sel_e      rd_sel,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] dir_q,
  input  logic         tmo_q,
  output logic [W-1:0] rd_data
);
  function automatic logic [W-1:0] in_view(input logic [W-1:0] pins,
                                           input logic [W-1:0] pol);
    return pins ^ pol;
  endfunction

  logic [W-1:0] rd_next;

  always_comb begin
    case (rd_sel)
      SEL_IN:  rd_next = in_view(pin_in, pol_q);
      SEL_OUT: rd_next = out_q;
      SEL_POL: rd_next = pol_q;
      SEL_DIR: rd_next = dir_q;
      SEL_TMO: rd_next = {{(W-1){1'b0}}, tmo_q};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_xpdr_bank.sv
module gpio_xpdr_bank import gx_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_n,
  input  logic [PTR_W-1:0] reg_ptr,
  input  logic             wr_stb,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_stb,
  output logic [W-1:0]     rd_data,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pin_out,
  output logic             tmo_en
);
  gx_sel_e      sel;
  logic [W-1:0] out_q, pol_q, dir_q;
  logic         tmo_q, wr_take;

  assign sel    = gx_decode(reg_ptr);
  assign tmo_en = tmo_q;

  gx_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .wr_stb(wr_stb), .wr_sel(sel), .wr_data(wr_data),
    .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q), .tmo_q(tmo_q),
    .wr_take(wr_take)
  );

  gx_pindrv #(.W(W)) u_pins (
    .ext_rst_n(ext_rst_n), .out_q(out_q), .dir_q(dir_q),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  gx_rdport #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sel(sel),
    .pin_in(pin_in), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
    .tmo_q(tmo_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/gx_bank_chk.sv
module gx_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ext_rst_n,
  input logic [7:0]   reg_ptr,
  input logic         wr_stb,
  input logic [W-1:0] wr_data,
  input logic         rd_stb,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic         tmo_en,
  input logic [W-1:0] pol_q,
  input logic [W-1:0] dir_q,
  input logic         wr_take
);
  logic hole;
  assign hole = (reg_ptr == 8'h00) || (reg_ptr > 8'h04);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_ptr == 8'h01 && ext_rst_n) |=> pin_out == $past(wr_data));

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_ptr == 8'h03 && ext_rst_n) |=> (!ext_rst_n || pin_oe == ~$past(wr_data)));

  assert_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && reg_ptr == 8'h00) |=> rd_data == $past(pin_in ^ pol_q));

  assert_tmo_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && reg_ptr == 8'h04 && ext_rst_n) |=> tmo_en == $past(wr_data[0]));

  assert_hole_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hole && ext_rst_n) |=> (pin_out == $past(pin_out) && pol_q == $past(pol_q) &&
                                       dir_q == $past(dir_q) && tmo_en == $past(tmo_en)));

  assert_hole_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && reg_ptr > 8'h04) |=> rd_data == '0);

  assert_hole_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hole |-> !wr_take);

  assert_ext_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |-> pin_oe == '0);

  assert_ext_dflt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |=> (pin_out == '0 && dir_q == '1 && tmo_en));
endmodule

bind gpio_xpdr_bank gx_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .reg_ptr(reg_ptr),
  .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
  .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .tmo_en(tmo_en),
  .pol_q(pol_q), .dir_q(dir_q), .wr_take(wr_take)
);

// File: tb/gpio_xpdr_bank_tb.sv
module gpio_xpdr_bank_tb;
  logic       clk = 0;
  logic       rst_n = 0, ext_rst_n = 1;
  logic [7:0] reg_ptr = 0, wr_data = 0, pin_in = 0;
  logic       wr_stb = 0, rd_stb = 0;
  logic [7:0] rd_data, pin_oe, pin_out;
  logic       tmo_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_out, m_pol, m_dir, m_tmo, m_rd;

  always #5 clk = ~clk;

  gpio_xpdr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .reg_ptr(reg_ptr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .tmo_en(tmo_en)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic model_defaults();
    m_out = 0; m_pol = 'hF0; m_dir = 'hFF; m_tmo = 1;
  endtask

  function automatic int model_read(int p);
    if (p == 0) return (pin_in ^ m_pol) & 'hFF;
    if (p == 1) return m_out;
    if (p == 2) return m_pol;
    if (p == 3) return m_dir;
    if (p == 4) return m_tmo;
    return 0;
  endfunction

  task automatic compare(input string tag);
    chk(tag, "pin_out", pin_out, m_out);
    chk(tag, "pin_oe", pin_oe, ext_rst_n ? (~m_dir & 'hFF) : 0);
    chk(tag, "tmo_en", tmo_en, m_tmo);
    chk(tag, "rd_data", rd_data, m_rd);
  endtask

  // one clock: drive on falling edge, model at rising edge, compare 1 ns later
  task automatic step(input string tag, input int p, input bit w, input int wd,
                      input bit r, input int pins, input bit ext);
    @(negedge clk);
    reg_ptr = p[7:0]; wr_stb = w; wr_data = wd[7:0]; rd_stb = r;
    pin_in = pins[7:0]; ext_rst_n = ext;
    @(posedge clk);
    if (r) m_rd = model_read(p);
    if (!ext) model_defaults();
    else if (w) begin
      if (p == 1) m_out = wd;
      else if (p == 2) m_pol = wd;
      else if (p == 3) m_dir = wd;
      else if (p == 4) m_tmo = wd & 1;
    end
    #1 compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_defaults(); m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 compare("R1");
    // R1 defaults read back through the port
    for (int p = 1; p <= 4; p++) step("R1", p, 0, 0, 1, 'h00, 1);
    step("R2", 2, 0, 0, 0, 'h00, 1);  // no strobe: rd_data holds
    // R3 output latch
    step("R3", 1, 1, 'hA5, 0, 'h00, 1);
    step("R3", 1, 0, 0, 1, 'h5A, 1);
    // R4 direction
    step("R4", 3, 1, 'h0F, 0, 'h00, 1);
    step("R4", 3, 0, 0, 1, 'h00, 1);
    step("R4", 3, 1, 'h00, 0, 'h00, 1);
    // R5 input view with default polarity, outputs included
    step("R5", 0, 0, 0, 1, 'h3C, 1);
    step("R5", 0, 0, 0, 1, 'hFF, 1);
    // R6 polarity
    step("R6", 2, 1, 'h00, 0, 'h3C, 1);
    step("R6", 0, 0, 0, 1, 'h3C, 1);
    step("R6", 2, 1, 'h81, 0, 'h3C, 1);
    step("R6", 2, 0, 0, 1, 'h3C, 1);
    step("R6", 0, 0, 0, 1, 'h3C, 1);
    // R7 timeout flag
    step("R7", 4, 1, 'hFE, 0, 0, 1);
    step("R7", 4, 0, 0, 1, 0, 1);
    step("R7", 4, 1, 'h03, 0, 0, 1);
    step("R7", 4, 0, 0, 1, 0, 1);
    // R8 ignored writes and empty reads
    step("R8", 0, 1, 'h77, 0, 'h11, 1);
    step("R8", 5, 1, 'h55, 1, 'h11, 1);
    step("R8", 'h80, 1, 'h00, 1, 'h11, 1);
    step("R8", 'hFF, 1, 'hFF, 1, 'h11, 1);
    for (int p = 1; p <= 4; p++) step("R8", p, 0, 0, 1, 'h11, 1);
    // R10 read and write in one cycle
    step("R10", 1, 1, 'h3E, 1, 0, 1);
    step("R10", 1, 0, 0, 1, 0, 1);
    // R9 external reset: enables drop in the same cycle
    step("R9", 3, 1, 'h00, 0, 0, 1);
    @(negedge clk); ext_rst_n = 0; wr_stb = 0; rd_stb = 0;
    #1 chk("R9", "pin_oe same cycle", pin_oe, 0);
    step("R9", 1, 1, 'hC3, 0, 0, 0);
    step("R9", 1, 0, 0, 1, 0, 1);
    for (int p = 2; p <= 4; p++) step("R9", p, 0, 0, 1, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule